// File: doc/BRIEF.md
# Core Nap and Wake Controller

This block decides when a processor core stops executing and when it resumes. The core signals a wait-for-interrupt request, a wait-for-event request, or a return from its last exception handler to thread level. The block then holds the core in a sleeping state and watches the interrupt lines. When the right condition appears, it raises a wake pulse. It also tells the core whether a pending interrupt may be dispatched to its handler, and it reports whether the sleep it entered is the deep variety.

Two wait flavours are supported, and their wake rules differ. An interrupt-wait resumes only for an interrupt that is enabled, pending and strictly more urgent than the current execution priority. An event-wait resumes for the same interrupts. It also resumes for a one-bit event flag, which can be set by an external signal-event strobe. When enabled by a control bit, the event flag is also set by any fresh rise of an interrupt pending bit, whether or not that interrupt is enabled or urgent enough. A global interrupt mask lets the core wake while dispatch stays blocked, so restore work can run first. A fault mask blocks interrupt wakes entirely. All control and status pins are plain levels; there is no streaming data path and so no valid/ready handshake.

Top module: `pwr_nap_ctrl`

## Requirements
- R1: After reset, `sleeping_o`, `deep_o`, `wake_o` and `dispatch_ok_o` are all 0.
- R2: While awake, a high `wait_irq_i` at a clock edge makes `sleeping_o` 1 from that edge on.
- R3: In an interrupt-wait, the core wakes only for an interrupt `i` with `irq_en_i[i]=1`, `irq_pend_i[i]=1` and priority field `irq_prio_i[i*PRIO_W +: PRIO_W]` numerically strictly below `cur_prio_i`. Equal priority, a disabled interrupt and `sev_i` do not wake it.
- R4: A wake condition present before edge k makes `wake_o` 1 for exactly the cycle after edge k. `sleeping_o` stays 1 during that cycle and is 0 from edge k+1 on.
- R5: With `fault_mask_i=1`, no interrupt wakes the core. With `irq_mask_i=1` and `fault_mask_i=0`, a qualifying interrupt still wakes the core, but `dispatch_ok_o` stays 0 until `irq_mask_i` returns to 0. `dispatch_ok_o` is never 1 while sleeping.
- R6: A high `exc_ret_i` while awake puts the core into an interrupt-wait at that edge only when `exit_nap_en_i=1`.
- R7: A wait-for-event issued while the event flag is set does not sleep. It clears the flag, so the next wait-for-event does sleep.
- R8: A wait-for-event issued with the event flag clear sleeps, and a qualifying interrupt (per R3) wakes it.
- R9: With `pend_evt_en_i=1` during an event-wait, a 0-to-1 change of any `irq_pend_i` bit wakes the core. This holds even if that interrupt is disabled or not urgent enough, and the event is consumed by the wake.
- R10: A pending bit already high at sleep entry is not a new event. With `pend_evt_en_i=0`, a fresh pend of a disabled interrupt does not wake an event-wait.
- R11: A `sev_i` pulse during an event-wait wakes the core.
- R12: `deep_o` equals `deep_en_i` as sampled at the sleep-entry edge. It holds that value for the whole sleep and is 0 while awake.
- R13: `wait_irq_i`, `wait_evt_i` and `exc_ret_i` have no effect while sleeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_irq_i | input | 1 | Wait-for-interrupt request |
| wait_evt_i | input | 1 | Wait-for-event request |
| exc_ret_i | input | 1 | Handler return to thread level |
| exit_nap_en_i | input | 1 | Sleep again after handler return |
| pend_evt_en_i | input | 1 | New pends generate events |
| deep_en_i | input | 1 | Request deep sleep on entry |
| irq_mask_i | input | 1 | Global interrupt dispatch mask |
| fault_mask_i | input | 1 | Mask that blocks all interrupt wakes |
| sev_i | input | 1 | External signal-event strobe |
| irq_en_i | input | N_IRQ | Per-interrupt enable |
| irq_pend_i | input | N_IRQ | Per-interrupt pending |
| irq_prio_i | input | N_IRQ*PRIO_W | Per-interrupt priority, lower is more urgent |
| cur_prio_i | input | PRIO_W | Current execution priority |
| sleeping_o | output | 1 | Core is asleep |
| deep_o | output | 1 | Current sleep is deep |
| wake_o | output | 1 | One-cycle wake pulse |
| dispatch_ok_o | output | 1 | Handler dispatch permitted |

## Verification
A wrong state register shows up at `sleeping_o` on the very next edge. Examples are an event-wait recorded as an interrupt-wait, or a wake cycle that never ends. The visible symptom is a wake that comes or fails to come within one cycle of its cause. A stale or lost event flag is invisible until the next wait-for-event: the core then either refuses to sleep or fails to wake. The bench therefore always follows an event with a second wait. Priority comparison faults appear as a wake on equal priority, one cycle after the interrupt is posted.

// File: rtl/nap_pkg.sv
package nap_pkg;
  typedef enum logic [1:0] {
    NAP_RUN  = 2'd0,
    NAP_IRQ  = 2'd1,
    NAP_EVT  = 2'd2,
    NAP_WAKE = 2'd3
  } nap_state_e;
endpackage

// File: rtl/nap_irq_eval.sv
module nap_irq_eval #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_IRQ-1:0]          irq_en_i,
  input  logic [N_IRQ-1:0]          irq_pend_i,
  input  logic [N_IRQ*PRIO_W-1:0]   irq_prio_i,
  input  logic [PRIO_W-1:0]         cur_prio_i,
  output logic                      any_beat_o,
  output logic                      any_new_o
);
  logic [N_IRQ-1:0] beat_v;
  logic [N_IRQ-1:0] new_v;
  logic [N_IRQ-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_pend_i;
  end

  // per-line qualification: enabled, pending, strictly more urgent
  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    logic [PRIO_W-1:0] line_prio;
    assign line_prio = irq_prio_i[g*PRIO_W +: PRIO_W];
    assign beat_v[g] = irq_en_i[g] & irq_pend_i[g] & (line_prio < cur_prio_i);
    assign new_v[g]  = irq_pend_i[g] & ~pend_q[g];
  end

  assign any_beat_o = |beat_v;
  assign any_new_o  = |new_v;
endmodule

// File: rtl/nap_evt_latch.sv
module nap_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic consume_i,
  output logic evt_q_o
);
  // consumption outranks a same-cycle set: the event is used by this wake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         evt_q_o <= 1'b0;
    else if (consume_i) evt_q_o <= 1'b0;
    else if (set_i)     evt_q_o <= 1'b1;
  end
endmodule

// File: rtl/nap_fsm.sv
module nap_fsm
  import nap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_irq_i,
  input  logic       wait_evt_i,
  input  logic       exc_ret_i,
  input  logic       exit_nap_en_i,
  input  logic       deep_en_i,
  input  logic       irq_wake_i,
  input  logic       evt_now_i,
  output nap_state_e state_o,
  output logic       deep_o,
  output logic       wake_o,
  output logic       consume_o
);
  nap_state_e state_q, state_d;
  logic       deep_q, deep_d;
  logic       wake_d;

  always_comb begin
    state_d   = state_q;
    deep_d    = deep_q;
    wake_d    = 1'b0;
    consume_o = 1'b0;
    unique case (state_q)
      NAP_RUN: begin
        deep_d = 1'b0;
        if (wait_irq_i || (exc_ret_i && exit_nap_en_i)) begin
          state_d = NAP_IRQ;
          deep_d  = deep_en_i;
        end else if (wait_evt_i) begin
          if (evt_now_i) begin
            consume_o = 1'b1;
          end else begin
            state_d = NAP_EVT;
            deep_d  = deep_en_i;
          end
        end
      end
      NAP_IRQ: begin
        if (irq_wake_i) begin
          state_d = NAP_WAKE;
          wake_d  = 1'b1;
        end
      end
      NAP_EVT: begin
        if (irq_wake_i || evt_now_i) begin
          state_d   = NAP_WAKE;
          wake_d    = 1'b1;
          consume_o = 1'b1;
        end
      end
      NAP_WAKE: begin
        state_d = NAP_RUN;
        deep_d  = 1'b0;
      end
      default: state_d = NAP_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= NAP_RUN;
      deep_q  <= 1'b0;
      wake_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      deep_q  <= deep_d;
      wake_o  <= wake_d;
    end
  end

  assign state_o = state_q;
  assign deep_o  = deep_q;
endmodule

// File: rtl/pwr_nap_ctrl.sv
module pwr_nap_ctrl
  import nap_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wait_irq_i,
  input  logic                     wait_evt_i,
  input  logic                     exc_ret_i,
  input  logic                     exit_nap_en_i,
  input  logic                     pend_evt_en_i,
  input  logic                     deep_en_i,
  input  logic                     irq_mask_i,
  input  logic                     fault_mask_i,
  input  logic                     sev_i,
  input  logic [N_IRQ-1:0]         irq_en_i,
  input  logic [N_IRQ-1:0]         irq_pend_i,
  input  logic [N_IRQ*PRIO_W-1:0]  irq_prio_i,
  input  logic [PRIO_W-1:0]        cur_prio_i,
  output logic                     sleeping_o,
  output logic                     deep_o,
  output logic                     wake_o,
  output logic                     dispatch_ok_o
);
  logic       any_beat, any_new;
  logic       irq_wake, evt_set, evt_q, evt_now, consume;
  nap_state_e state;

  nap_irq_eval #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en_i   (irq_en_i),
    .irq_pend_i (irq_pend_i),
    .irq_prio_i (irq_prio_i),
    .cur_prio_i (cur_prio_i),
    .any_beat_o (any_beat),
    .any_new_o  (any_new)
  );

  assign irq_wake = any_beat & ~fault_mask_i;
  assign evt_set  = sev_i | (pend_evt_en_i & any_new);
  assign evt_now  = evt_q | evt_set;

  nap_evt_latch u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (evt_set),
    .consume_i (consume),
    .evt_q_o   (evt_q)
  );

  nap_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .wait_irq_i    (wait_irq_i),
    .wait_evt_i    (wait_evt_i),
    .exc_ret_i     (exc_ret_i),
    .exit_nap_en_i (exit_nap_en_i),
    .deep_en_i     (deep_en_i),
    .irq_wake_i    (irq_wake),
    .evt_now_i     (evt_now),
    .state_o       (state),
    .deep_o        (deep_o),
    .wake_o        (wake_o),
    .consume_o     (consume)
  );

  assign sleeping_o    = (state != NAP_RUN);
  assign dispatch_ok_o = (state == NAP_RUN) & any_beat & ~irq_mask_i & ~fault_mask_i;
endmodule

// File: rtl/nap_ctrl_chk.sv
module nap_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wait_irq_i,
  input logic irq_mask_i,
  input logic sleeping_o,
  input logic deep_o,
  input logic wake_o,
  input logic dispatch_ok_o
);
  p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping_o && wait_irq_i) |=> sleeping_o);
  p_pulse_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
  p_wake_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> sleeping_o);
  p_sleep_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !sleeping_o);
  p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask_i |-> !dispatch_ok_o);
  p_no_dispatch_asleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping_o |-> !dispatch_ok_o);
  p_deep_in_sleep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    deep_o |-> sleeping_o);
  p_deep_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping_o && $past(sleeping_o)) |-> $stable(deep_o));
endmodule

bind pwr_nap_ctrl nap_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wait_irq_i    (wait_irq_i),
  .irq_mask_i    (irq_mask_i),
  .sleeping_o    (sleeping_o),
  .deep_o        (deep_o),
  .wake_o        (wake_o),
  .dispatch_ok_o (dispatch_ok_o)
);

// File: tb/sim_pwr_nap_ctrl.sv
module sim_pwr_nap_ctrl;
  localparam int N = 8;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_irq = 0, wait_evt = 0, exc_ret = 0, exit_en = 0, pend_evt_en = 0;
  logic deep_en = 0, irq_mask = 0, fault_mask = 0, sev = 0;
  logic [N-1:0] en = '0, pend = '0;
  logic [N*PW-1:0] prio;
  logic [PW-1:0] cur = 3'd7;
  logic sleeping, deep, wake, disp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // irq i has priority value i
  always_comb for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'(i);

  pwr_nap_ctrl #(.N_IRQ(N), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .wait_irq_i(wait_irq), .wait_evt_i(wait_evt),
    .exc_ret_i(exc_ret), .exit_nap_en_i(exit_en), .pend_evt_en_i(pend_evt_en),
    .deep_en_i(deep_en), .irq_mask_i(irq_mask), .fault_mask_i(fault_mask),
    .sev_i(sev), .irq_en_i(en), .irq_pend_i(pend), .irq_prio_i(prio),
    .cur_prio_i(cur), .sleeping_o(sleeping), .deep_o(deep), .wake_o(wake),
    .dispatch_ok_o(disp));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // expects wake pulse this cycle, awake next
  task automatic expect_wake(string req);
    chk(req, "wake pulse", wake, 1'b1);
    chk(req, "still asleep in pulse", sleeping, 1'b1);
    step();
    chk(req, "pulse ended", wake, 1'b0);
    chk(req, "awake after pulse", sleeping, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1", "sleeping", sleeping, 1'b0);
    chk("R1", "deep", deep, 1'b0);
    chk("R1", "wake", wake, 1'b0);
    chk("R1", "dispatch", disp, 1'b0);
  endtask

  task automatic t_wfi();
    wait_irq = 1; step(); wait_irq = 0;
    chk("R2", "entered sleep", sleeping, 1'b1);
    en[7] = 1; pend[7] = 1; step();
    chk("R3", "equal prio no wake", wake, 1'b0);
    en[7] = 0; pend[7] = 0; pend[3] = 1; step();
    chk("R3", "disabled no wake", wake, 1'b0);
    sev = 1; step(); sev = 0;
    chk("R3", "event ignored by irq-wait", wake, 1'b0);
    en[3] = 1; step();
    expect_wake("R4");
    chk("R5", "dispatch when unmasked", disp, 1'b1);
    en = '0; pend = '0; step();
  endtask

  task automatic t_latched();
    wait_evt = 1; step();
    chk("R7", "flag set: no sleep", sleeping, 1'b0);
    step(); wait_evt = 0;
    chk("R7", "flag consumed: sleeps", sleeping, 1'b1);
    step();
    chk("R8", "no wake without cause", wake, 1'b0);
    en[2] = 1; pend[2] = 1; step();
    expect_wake("R8");
    en = '0; pend = '0; step();
  endtask

  task automatic t_mask();
    irq_mask = 1; wait_irq = 1; step(); wait_irq = 0;
    en[1] = 1; pend[1] = 1; step();
    expect_wake("R5");
    chk("R5", "dispatch held by mask", disp, 1'b0);
    irq_mask = 0; #1;
    chk("R5", "dispatch after unmask", disp, 1'b1);
    step();
    fault_mask = 1; wait_irq = 1; step(); wait_irq = 0;
    step(); step();
    chk("R5", "fault mask blocks wake", wake, 1'b0);
    chk("R5", "fault mask still asleep", sleeping, 1'b1);
    fault_mask = 0; step();
    expect_wake("R5");
    en = '0; pend = '0; step();
  endtask

  task automatic t_exit();
    exc_ret = 1; step(); exc_ret = 0;
    chk("R6", "return without exit-nap stays awake", sleeping, 1'b0);
    exit_en = 1; exc_ret = 1; step(); exc_ret = 0; exit_en = 0;
    chk("R6", "return with exit-nap sleeps", sleeping, 1'b1);
    en[0] = 1; pend[0] = 1; step();
    expect_wake("R6");
    en = '0; pend = '0; step();
  endtask

  task automatic t_pend_evt();
    pend[5] = 1; step();
    pend_evt_en = 1; wait_evt = 1; step(); wait_evt = 0;
    chk("R10", "event-wait entered", sleeping, 1'b1);
    step();
    chk("R10", "old pend no event", wake, 1'b0);
    cur = 3'd2; en[6] = 1; pend[6] = 1; step();
    expect_wake("R9");
    pend = '0; en = '0; cur = 3'd7; pend_evt_en = 0; step();
    wait_evt = 1; step(); wait_evt = 0;
    chk("R10", "sleeps again (event consumed)", sleeping, 1'b1);
    pend[4] = 1; step();
    chk("R10", "pend-events off: no wake", wake, 1'b0);
    sev = 1; step(); sev = 0;
    expect_wake("R11");
    pend = '0; step();
  endtask

  task automatic t_deep();
    deep_en = 1; wait_irq = 1; step(); wait_irq = 0;
    chk("R12", "deep at entry", deep, 1'b1);
    deep_en = 0; step();
    chk("R12", "deep held", deep, 1'b1);
    en[1] = 1; pend[1] = 1; step();
    step();
    chk("R12", "deep cleared awake", deep, 1'b0);
    en = '0; pend = '0;
    wait_irq = 1; step(); wait_irq = 0;
    chk("R12", "shallow sleep", deep, 1'b0);
    en[1] = 1; pend[1] = 1; step(); step();
    en = '0; pend = '0; step();
  endtask

  task automatic t_ignore();
    wait_irq = 1; step(); wait_irq = 0;
    wait_evt = 1; exc_ret = 1; exit_en = 1; step();
    wait_evt = 0; exc_ret = 0; exit_en = 0;
    chk("R13", "requests ignored: no wake", wake, 1'b0);
    chk("R13", "requests ignored: asleep", sleeping, 1'b1);
    en[0] = 1; pend[0] = 1; step();
    expect_wake("R13");
    en = '0; pend = '0; step();
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1; step();
    t_wfi();
    t_latched();
    t_mask();
    t_exit();
    t_pend_evt();
    t_deep();
    t_ignore();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule